// File: doc/BRIEF.md
# Nested Interrupt Context Stack Register

This block is a 32-bit control/status register that follows which external interrupt the core is currently servicing. It also keeps a three-deep stack of preemption thresholds. When the core enters the external interrupt vector, the stack is pushed in hardware. A return from that handler pops it again, provided the entry left a restore flag set. Software asks, through an update strobe from the selection logic, for the current interrupt number and a new threshold to be loaded. The new threshold is one above the selected priority, but it never drops below the threshold of the frame that was preempted.

A second function lets a handler mask the standard timer and software interrupt enables in one write, and keep their previous values. The handler then re-enables global interrupts without being preempted by handlers that do not follow the nested scheme. Writing the saved values back sets the enables again. The threshold also gates a candidate interrupt: a request is passed to the core only when its priority reaches the threshold.

The block takes one event per cycle. A trap entry outranks a return, a return outranks an update, and an update outranks a CSR write. An event that loses has no effect.

Top module: `irq_ctx_stack`

## Requirements
- R1: After reset the register reads 0x0000_8000: only the idle flag (bit 15) is 1. Bits 23:21, 14:13 and 1 always read 0.
- R2: The threshold (bits 20:16) is 5 bits wide. Saved entries are 4 bits wide. A threshold above 15 is pushed as 15.
- R3: A trap entry with the external flag set pushes the stack in one cycle. Bits 31:28 take bits 27:24, and bits 27:24 take the (saturated) threshold. The restore flag (bit 0) is set, and the threshold is unchanged.
- R4: A return with the restore flag set pops the stack. The threshold takes the old bits 27:24, bits 27:24 take the old bits 31:28, and bits 31:28 become 0. A return always clears the restore flag. With the flag clear, nothing else changes.
- R5: A trap entry without the external flag clears only the restore flag.
- R6: An update strobe sets the threshold to max(priority+1, bits 27:24). It copies the index into bits 12:4 and the idle input into bit 15.
- R7: A CSR write with bit 1 set pulses the timer and soft enable clear outputs for that cycle. It captures the enable inputs into bit 3 (timer) and bit 2 (soft). A CSR write with bit 1 clear sets bits 3 and 2 to 0.
- R8: A CSR write with bit 1 clear pulses the timer set output when bit 3 is written 1, and the soft set output when bit 2 is written 1. A clear pulse and a set pulse never occur together.
- R9: Only one event acts per cycle, in the order trap entry, return, update, CSR write. The others are ignored, and a write that loses produces no enable pulse.
- R10: irq_req is 1 exactly when cand_valid is 1 and cand_prio is at least the threshold. The comparison uses the threshold as it stands at that moment.
- R11: A winning CSR write loads bits 31:28, 27:24, 20:16, 15, 12:4 and 0 from the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wen | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read value |
| trap_take | input | 1 | Core enters a trap this cycle |
| trap_is_ext | input | 1 | Trap is the external interrupt |
| trap_ret | input | 1 | Return from trap |
| upd_stb | input | 1 | Update request from selection logic |
| upd_idle | input | 1 | Selection found no interrupt |
| upd_index | input | 9 | Selected interrupt index |
| upd_prio | input | 4 | Selected interrupt priority |
| tmr_en_i | input | 1 | Current timer interrupt enable |
| sw_en_i | input | 1 | Current soft interrupt enable |
| tmr_en_clr | output | 1 | Clear timer enable |
| tmr_en_set | output | 1 | Set timer enable |
| sw_en_clr | output | 1 | Clear soft enable |
| sw_en_set | output | 1 | Set soft enable |
| cand_valid | input | 1 | A candidate interrupt is pending |
| cand_prio | input | 4 | Candidate priority |
| irq_req | output | 1 | Candidate is allowed to interrupt |

## Verification
The bench aims at four cases:
- Nesting depth. It runs two nested entries and unwinds them. A design that drops or duplicates an entry would leave a wrong threshold after the second return.
- Saturation. It pushes a threshold of 16. A design that truncates instead of saturating would save 0 and reopen every priority.
- The update floor. It issues an update whose priority is below the preempted frame's. A design without the floor would let the preempted handler re-enter.
- Collisions. It drives trap, return, update and write together. A design with the wrong order would lose the push, or would emit enable pulses for a write that was dropped.

// File: rtl/ictx_pkg.sv
package ictx_pkg;
    localparam int CSR_W  = 32;
    localparam int IDX_W  = 9;
    localparam int PRIO_W = 4;
    localparam int TH_W   = PRIO_W + 1;
    localparam int P_STK2 = 28;
    localparam int P_STK1 = 24;
    localparam int P_TH   = 16;
    localparam int P_IDLE = 15;
    localparam int P_IRQ  = 4;
    localparam int P_TSV  = 3;
    localparam int P_SSV  = 2;
    localparam int P_MASK = 1;
    localparam int P_RET  = 0;
    localparam logic [PRIO_W-1:0] PRIO_MAX = {PRIO_W{1'b1}};

    typedef struct packed {
        logic [PRIO_W-1:0] stk2;
        logic [PRIO_W-1:0] stk1;
        logic [TH_W-1:0]   thresh;
        logic              idle;
        logic [IDX_W-1:0]  cur_irq;
        logic              tmr_save;
        logic              sw_save;
        logic              ret_pop;
    } ctx_t;

    function automatic logic [PRIO_W-1:0] sat_prio(input logic [TH_W-1:0] t);
        return t[TH_W-1] ? PRIO_MAX : t[PRIO_W-1:0];
    endfunction
endpackage

// File: rtl/ictx_pack.sv
module ictx_pack
    import ictx_pkg::*;
(
    input  ctx_t             ctx,
    output logic [CSR_W-1:0] rdata
);
    always_comb begin
        rdata                   = '0;
        rdata[P_STK2 +: PRIO_W] = ctx.stk2;
        rdata[P_STK1 +: PRIO_W] = ctx.stk1;
        rdata[P_TH +: TH_W]     = ctx.thresh;
        rdata[P_IDLE]           = ctx.idle;
        rdata[P_IRQ +: IDX_W]   = ctx.cur_irq;
        rdata[P_TSV]            = ctx.tmr_save;
        rdata[P_SSV]            = ctx.sw_save;
        rdata[P_RET]            = ctx.ret_pop;
    end
endmodule

// File: rtl/ictx_gate.sv
module ictx_gate
    import ictx_pkg::*;
(
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [TH_W-1:0]   thresh,
    output logic              req
);
    always_comb req = cand_valid && ({1'b0, cand_prio} >= thresh);
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
    import ictx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wen,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic              trap_take,
    input  logic              trap_is_ext,
    input  logic              trap_ret,
    input  logic              upd_stb,
    input  logic              upd_idle,
    input  logic [IDX_W-1:0]  upd_index,
    input  logic [PRIO_W-1:0] upd_prio,
    input  logic              tmr_en_i,
    input  logic              sw_en_i,
    output logic              tmr_en_clr,
    output logic              tmr_en_set,
    output logic              sw_en_clr,
    output logic              sw_en_set,
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              irq_req
);
    ctx_t            ctx_d, ctx_q;
    logic [TH_W-1:0] upd_th;
    logic [TH_W-1:0] floor_th;

    always_comb begin
        ctx_d      = ctx_q;
        tmr_en_clr = 1'b0;
        tmr_en_set = 1'b0;
        sw_en_clr  = 1'b0;
        sw_en_set  = 1'b0;
        upd_th     = TH_W'(upd_prio) + TH_W'(1);
        floor_th   = {1'b0, ctx_q.stk1};
        if (trap_take) begin
            if (trap_is_ext) begin
                ctx_d.stk2    = ctx_q.stk1;
                ctx_d.stk1    = sat_prio(ctx_q.thresh);
                ctx_d.ret_pop = 1'b1;
            end else begin
                ctx_d.ret_pop = 1'b0;
            end
        end else if (trap_ret) begin
            if (ctx_q.ret_pop) begin
                ctx_d.thresh = floor_th;
                ctx_d.stk1   = ctx_q.stk2;
                ctx_d.stk2   = '0;
            end
            ctx_d.ret_pop = 1'b0;
        end else if (upd_stb) begin
            ctx_d.thresh  = (upd_th > floor_th) ? upd_th : floor_th;
            ctx_d.cur_irq = upd_index;
            ctx_d.idle    = upd_idle;
        end else if (csr_wen) begin
            ctx_d.stk2    = csr_wdata[P_STK2 +: PRIO_W];
            ctx_d.stk1    = csr_wdata[P_STK1 +: PRIO_W];
            ctx_d.thresh  = csr_wdata[P_TH +: TH_W];
            ctx_d.idle    = csr_wdata[P_IDLE];
            ctx_d.cur_irq = csr_wdata[P_IRQ +: IDX_W];
            ctx_d.ret_pop = csr_wdata[P_RET];
            if (csr_wdata[P_MASK]) begin
                ctx_d.tmr_save = tmr_en_i;
                ctx_d.sw_save  = sw_en_i;
                tmr_en_clr     = 1'b1;
                sw_en_clr      = 1'b1;
            end else begin
                ctx_d.tmr_save = 1'b0;
                ctx_d.sw_save  = 1'b0;
                tmr_en_set     = csr_wdata[P_TSV];
                sw_en_set      = csr_wdata[P_SSV];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q      <= '0;
            ctx_q.idle <= 1'b1;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    ictx_pack u_pack (
        .ctx   (ctx_q),
        .rdata (csr_rdata)
    );

    ictx_gate u_gate (
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .thresh     (ctx_q.thresh),
        .req        (irq_req)
    );
endmodule

// File: rtl/ictx_checker.sv
module ictx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_take,
    input logic        trap_is_ext,
    input logic        trap_ret,
    input logic        upd_stb,
    input logic [3:0]  upd_prio,
    input logic        cand_valid,
    input logic [3:0]  cand_prio,
    input logic [31:0] csr_rdata,
    input logic        irq_req,
    input logic        tmr_en_clr,
    input logic        tmr_en_set,
    input logic        sw_en_clr,
    input logic        sw_en_set
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[23:21] == 3'd0 && csr_rdata[14:13] == 2'd0 && !csr_rdata[1]);

    a_r3_push: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take && trap_is_ext |=> csr_rdata[0]
            && csr_rdata[31:28] == $past(csr_rdata[27:24])
            && csr_rdata[27:24] == ($past(csr_rdata[20]) ? 4'hF : $past(csr_rdata[19:16])));

    a_r5_other_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take && !trap_is_ext |=> !csr_rdata[0]);

    a_r4_ret_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take && trap_ret |=> !csr_rdata[0]);

    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take && !trap_ret && upd_stb |=>
            csr_rdata[20:16] >= {1'b0, $past(csr_rdata[27:24])}
            && csr_rdata[20:16] > {1'b0, $past(upd_prio)});

    a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_en_clr && tmr_en_set) && !(sw_en_clr && sw_en_set));

    a_r9_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> !tmr_en_clr && !tmr_en_set && !sw_en_clr && !sw_en_set);

    a_r10_req_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> cand_valid && {1'b0, cand_prio} >= csr_rdata[20:16]);
endmodule

bind irq_ctx_stack ictx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_take   (trap_take),
    .trap_is_ext (trap_is_ext),
    .trap_ret    (trap_ret),
    .upd_stb     (upd_stb),
    .upd_prio    (upd_prio),
    .cand_valid  (cand_valid),
    .cand_prio   (cand_prio),
    .csr_rdata   (csr_rdata),
    .irq_req     (irq_req),
    .tmr_en_clr  (tmr_en_clr),
    .tmr_en_set  (tmr_en_set),
    .sw_en_clr   (sw_en_clr),
    .sw_en_set   (sw_en_set)
);

// File: tb/irq_ctx_stack_bench.sv
`timescale 1ns/1ps
module irq_ctx_stack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wen = 0, trap_take = 0, trap_is_ext = 0, trap_ret = 0;
    logic        upd_stb = 0, upd_idle = 0, tmr_en_i = 0, sw_en_i = 0, cand_valid = 0;
    logic [31:0] csr_wdata = '0;
    logic [8:0]  upd_index = '0;
    logic [3:0]  upd_prio = '0, cand_prio = '0;
    logic [31:0] csr_rdata;
    logic        tmr_en_clr, tmr_en_set, sw_en_clr, sw_en_set, irq_req;

    int n_cmp = 0, n_bad = 0;
    int m_s2, m_s1, m_th, m_idle, m_irq, m_ts, m_ss, m_rp;

    always #4 clk = ~clk;

    irq_ctx_stack u_irq_ctx_stack (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_pack();
        return (32'(m_s2) << 28) | (32'(m_s1) << 24) | (32'(m_th) << 16) | (32'(m_idle) << 15)
             | (32'(m_irq) << 4) | (32'(m_ts) << 3) | (32'(m_ss) << 2) | 32'(m_rp);
    endfunction

    task automatic idle_in();
        csr_wen = 0; trap_take = 0; trap_is_ext = 0; trap_ret = 0; upd_stb = 0;
    endtask

    task automatic step(input string tag);
        int win, c;
        logic [3:0] ep;
        #1;
        win = trap_take ? 0 : trap_ret ? 1 : upd_stb ? 2 : csr_wen ? 3 : 4;
        ep[3] = (win == 3) && csr_wdata[1];
        ep[2] = (win == 3) && !csr_wdata[1] && csr_wdata[3];
        ep[1] = (win == 3) && csr_wdata[1];
        ep[0] = (win == 3) && !csr_wdata[1] && csr_wdata[2];
        chk(tag, "pulses", {28'd0, tmr_en_clr, tmr_en_set, sw_en_clr, sw_en_set}, {28'd0, ep});
        chk("R10", "irq_req", {31'd0, irq_req}, {31'd0, cand_valid && int'(cand_prio) >= m_th});
        @(posedge clk);
        if (win == 0) begin
            if (trap_is_ext) begin
                m_s2 = m_s1; m_s1 = (m_th > 15) ? 15 : m_th; m_rp = 1;
            end else m_rp = 0;
        end else if (win == 1) begin
            if (m_rp == 1) begin m_th = m_s1; m_s1 = m_s2; m_s2 = 0; end
            m_rp = 0;
        end else if (win == 2) begin
            c = int'(upd_prio) + 1;
            m_th = (c > m_s1) ? c : m_s1;
            m_irq = int'(upd_index); m_idle = int'(upd_idle);
        end else if (win == 3) begin
            m_s2 = int'(csr_wdata[31:28]); m_s1 = int'(csr_wdata[27:24]);
            m_th = int'(csr_wdata[20:16]); m_idle = int'(csr_wdata[15]);
            m_irq = int'(csr_wdata[12:4]); m_rp = int'(csr_wdata[0]);
            if (csr_wdata[1]) begin m_ts = int'(tmr_en_i); m_ss = int'(sw_en_i); end
            else begin m_ts = 0; m_ss = 0; end
        end
        @(negedge clk);
        chk(tag, "rdata", csr_rdata, m_pack());
        idle_in();
    endtask

    task automatic ext_entry(input string tag);
        trap_take = 1; trap_is_ext = 1; step(tag);
    endtask
    task automatic do_ret(input string tag);
        trap_ret = 1; step(tag);
    endtask
    task automatic do_upd(input string tag, input int idx, input int pr);
        upd_stb = 1; upd_index = 9'(idx); upd_prio = 4'(pr); upd_idle = 0; step(tag);
    endtask
    task automatic do_wr(input string tag, input logic [31:0] d);
        csr_wen = 1; csr_wdata = d; step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_s2 = 0; m_s1 = 0; m_th = 0; m_idle = 1; m_irq = 0; m_ts = 0; m_ss = 0; m_rp = 0;
        repeat (3) @(negedge clk);
        chk("R1", "reset value", csr_rdata, 32'h0000_8000);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "after release", csr_rdata, 32'h0000_8000);

        // R11: write all writable fields; reserved and mask bit read back zero
        do_wr("R11", 32'hFFFF_FFF1);
        do_wr("R11", 32'h0000_0000);

        // R3 / R6: entry, update, then floor case
        ext_entry("R3");
        do_upd("R6", 5, 6);            // threshold 7
        ext_entry("R3");               // stk1 = 7
        do_upd("R6", 9, 2);            // 3 < 7 -> floor keeps 7
        chk("R6", "floor thresh", {27'd0, csr_rdata[20:16]}, 32'd7);
        do_upd("R6", 12, 10);          // threshold 11
        // R4: nested unwind
        do_ret("R4");
        chk("R4", "popped thresh", {27'd0, csr_rdata[20:16]}, 32'd7);
        do_ret("R4");                  // flag clear: no pop
        chk("R4", "no second pop", {27'd0, csr_rdata[20:16]}, 32'd7);

        // R5: other trap clears only the flag
        ext_entry("R3");
        trap_take = 1; trap_is_ext = 0; step("R5");
        do_ret("R5");

        // R2: threshold 16 saturates on push
        do_upd("R2", 1, 15);
        chk("R2", "thresh 16", {27'd0, csr_rdata[20:16]}, 32'd16);
        ext_entry("R2");
        chk("R2", "saturated save", {28'd0, csr_rdata[27:24]}, 32'd15);
        do_ret("R2");

        // R7 / R8: mask, readback, restore
        tmr_en_i = 1; sw_en_i = 0;
        do_wr("R7", 32'h0000_0002);
        chk("R7", "saved bits", {30'd0, csr_rdata[3:2]}, 32'd2);
        tmr_en_i = 0;
        do_wr("R8", 32'h0000_0008);
        do_wr("R8", 32'h0000_0004);
        do_wr("R7", 32'h0000_000E);    // mask wins over save bits

        // R9: collisions
        trap_take = 1; trap_is_ext = 1; trap_ret = 1; upd_stb = 1; csr_wen = 1;
        csr_wdata = 32'h0000_000A; step("R9");
        trap_ret = 1; upd_stb = 1; upd_prio = 3; csr_wen = 1; csr_wdata = 32'h0000_0002; step("R9");
        upd_stb = 1; upd_prio = 8; csr_wen = 1; csr_wdata = 32'h0000_0002; step("R9");

        // R10: gating sweep
        do_wr("R10", 32'h0005_0000);
        for (int p = 0; p < 16; p++) begin
            cand_valid = 1; cand_prio = 4'(p); step("R10");
        end
        cand_valid = 0; step("R10");

        // R9: mixed random traffic
        for (int i = 0; i < 400; i++) begin
            trap_take   = ($urandom_range(0, 7) == 0);
            trap_is_ext = $urandom_range(0, 1) == 1;
            trap_ret    = ($urandom_range(0, 5) == 0);
            upd_stb     = ($urandom_range(0, 4) == 0);
            upd_idle    = $urandom_range(0, 1) == 1;
            upd_index   = 9'($urandom_range(0, 511));
            upd_prio    = 4'($urandom_range(0, 15));
            csr_wen     = ($urandom_range(0, 4) == 0);
            csr_wdata   = $urandom;
            tmr_en_i    = $urandom_range(0, 1) == 1;
            sw_en_i     = $urandom_range(0, 1) == 1;
            cand_valid  = $urandom_range(0, 1) == 1;
            cand_prio   = 4'($urandom_range(0, 15));
            step("R9");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule